// File: doc/BRIEF.md
# DDR Read Capture with Edge-Split FIFOs

This block takes read data arriving from a DDR memory and hands it to the internal read clock, which runs a quarter period behind the system clock. The memory returns one byte on each edge of its delayed data strobe. The block writes each byte directly into one of two shallow FIFOs, with no register stage between the pins and the storage. Bytes taken on a rising strobe edge go to one FIFO and bytes taken on a falling edge go to the other. A capture enable, produced in the strobe domain, decides which strobe edges store data.

On the read side, each FIFO's Gray-coded write pointer passes through a two-flop synchronizer clocked by the read clock. A FIFO is empty when the synchronized write pointer equals its own Gray read pointer. The valid flag is high only when neither FIFO is empty. In every read-clock cycle where valid is high, the oldest rising-edge byte and the oldest falling-edge byte are presented together, and both read pointers step forward at the next read-clock edge.

The writer has no flow control. The reader drains one pair per cycle, so the depth only has to cover the synchronizer delay across one burst.

Top module: `ddr_rdcap`

## Requirements
- R1: `rise_word` carries a byte stored on a rising edge of `dqs`, and `fall_word` carries a byte stored on a falling edge. Within one cycle where `rd_valid` is high, the two words are the n-th rising byte and the n-th falling byte.
- R2: Each output word stream delivers its bytes in the order the strobe edges stored them.
- R3: `rd_valid` is high exactly when both FIFOs hold at least one unread byte. If one FIFO holds data and the other is empty, `rd_valid` stays low.
- R4: A byte stored by a strobe edge that falls between read-clock rising edges k-1 and k is first counted as present after rising edge k+1. This is the two-stage crossing of the Gray write pointer, and the synchronized pointer moves by at most one bit per read-clock cycle.
- R5: At each read-clock rising edge where `rd_valid` is high, exactly one pair is consumed. While `rd_valid` is low, the read pointers hold and the presented words do not advance.
- R6: A strobe edge seen while `cap_en` is low stores nothing. It changes neither FIFO's contents nor `rd_valid`.
- R7: While `rst` is high, all pointers and synchronizer stages are zero, both FIFOs are empty, and `rd_valid` is low. Data stored before a reset is never delivered after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous active-high reset for both clock domains |
| dqs | input | 1 | Delayed data strobe; both edges store data |
| cap_en | input | 1 | Capture enable, generated in the strobe domain |
| dq | input | DW | Read data from the memory pins |
| rd_clk | input | 1 | Read clock, 90 degrees behind the system clock |
| rise_word | output | DW | Oldest unread byte stored on a rising strobe edge |
| fall_word | output | DW | Oldest unread byte stored on a falling strobe edge |
| rd_valid | output | 1 | Both words are valid and are consumed at the next read-clock edge |

## Verification
Each stored byte becomes visible two read-clock rising edges after its strobe edge. Consumption takes effect at the first rising edge where `rd_valid` is high, so the next pair shows up right after that edge.

The bench places every strobe edge at a fixed fraction of a read-clock period away from both read-clock edges. At each read-clock rising edge it updates a behavioural model that counts stored bytes through two delay slots. It compares `rd_valid` and both words at the falling edge that follows, so every comparison sees settled values.

The stimulus varies the strobe phase. It includes edges with capture disabled, a lone rising or falling capture that leaves the FIFOs unbalanced, and a reset that arrives while data is still unread.

// File: rtl/ddr_rdcap.sv
module ddr_rdcap #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          rst,
  input  logic          dqs,
  input  logic          cap_en,
  input  logic [DW-1:0] dq,
  input  logic          rd_clk,
  output logic [DW-1:0] rise_word,
  output logic [DW-1:0] fall_word,
  output logic          rd_valid
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [1:0][DW-1:0] word;
  logic [1:0]         ready;
  logic [1:0][PW-1:0] rg_all, s2_all;

  for (genvar e = 0; e < 2; e++) begin : g_fifo
    logic          wclk;
    logic [PW-1:0] wb, wg, s1, s2, rb, rg;
    logic [DW-1:0] mem [DEPTH];

    assign wclk = (e == 0) ? dqs : ~dqs;

    always_ff @(posedge wclk or posedge rst)
      if (rst) begin
        wb <= '0;
        wg <= '0;
      end else if (cap_en) begin
        wb <= PW'(wb + 1'b1);
        wg <= to_gray(PW'(wb + 1'b1));
      end

    always_ff @(posedge wclk)
      if (cap_en) mem[wb[AW-1:0]] <= dq;

    always_ff @(posedge rd_clk or posedge rst)
      if (rst) begin
        s1 <= '0;
        s2 <= '0;
      end else begin
        s1 <= wg;
        s2 <= s1;
      end

    always_ff @(posedge rd_clk or posedge rst)
      if (rst) begin
        rb <= '0;
        rg <= '0;
      end else if (rd_valid) begin
        rb <= PW'(rb + 1'b1);
        rg <= to_gray(PW'(rb + 1'b1));
      end

    assign ready[e]  = (s2 != rg);
    assign word[e]   = mem[rb[AW-1:0]];
    assign rg_all[e] = rg;
    assign s2_all[e] = s2;
  end

  assign rd_valid  = &ready;
  assign rise_word = word[0];
  assign fall_word = word[1];
endmodule

// File: rtl/ddr_rdcap_chk.sv
module ddr_rdcap_chk #(
  parameter int PW = 3
) (
  input logic               rd_clk,
  input logic               rst,
  input logic               rd_valid,
  input logic [1:0][PW-1:0] rg,
  input logic [1:0][PW-1:0] s2
);
  p_gray_step_r4: assert property (@(posedge rd_clk) disable iff (rst)
    ($countones(s2[0] ^ $past(s2[0])) <= 1) && ($countones(s2[1] ^ $past(s2[1])) <= 1));

  p_same_ptr_r5: assert property (@(posedge rd_clk) disable iff (rst)
    rg[0] == rg[1]);

  p_hold_r5: assert property (@(posedge rd_clk) disable iff (rst)
    !rd_valid |=> $stable(rg));

  p_adv_r5: assert property (@(posedge rd_clk) disable iff (rst)
    rd_valid |=> (rg[0] != $past(rg[0])));

  p_reset_r7: assert property (@(posedge rd_clk)
    rst |=> (!rd_valid && rg[0] == '0 && rg[1] == '0));
endmodule

bind ddr_rdcap ddr_rdcap_chk #(.PW(PW)) u_chk (
  .rd_clk  (rd_clk),
  .rst     (rst),
  .rd_valid(rd_valid),
  .rg      (rg_all),
  .s2      (s2_all)
);

// File: tb/sim_ddr_rdcap.sv
`timescale 1ns/100ps
module sim_ddr_rdcap;
  logic       rst = 1'b1, dqs = 1'b0, cap_en = 1'b0, clk = 1'b0;
  logic [7:0] dq = '0, rise_word, fall_word;
  logic       rd_valid;

  ddr_rdcap #(.DW(8), .DEPTH(4)) u0 (
    .rst(rst), .dqs(dqs), .cap_en(cap_en), .dq(dq), .rd_clk(clk),
    .rise_word(rise_word), .fall_word(fall_word), .rd_valid(rd_valid)
  );

  always #2 clk = ~clk;

  int         vectors = 0, miscompares = 0;
  int         wr0 = 0, wr1 = 0, s1r = 0, s2r = 0, s1f = 0, s2f = 0, rdn = 0;
  logic [7:0] qr[$], qf[$];
  logic       mv = 1'b0;
  string      tag = "R7";

  always @(posedge clk) if (!rst) begin
    if (mv) begin
      rdn++;
      void'(qr.pop_front());
      void'(qf.pop_front());
    end
    s2r = s1r; s1r = wr0;
    s2f = s1f; s1f = wr1;
  end

  always @(negedge clk) if (!rst) begin
    mv = (s2r > rdn) && (s2f > rdn);
    vectors++;
    if (rd_valid !== mv) begin
      miscompares++;
      $display("FAIL R3/R4 (%s) t=%0t rd_valid=%b expected %b", tag, $time, rd_valid, mv);
    end
    if (mv) begin
      vectors++;
      if (rise_word !== qr[0] || fall_word !== qf[0]) begin
        miscompares++;
        $display("FAIL R1/R2/R5 (%s) t=%0t words=%h/%h expected %h/%h",
                 tag, $time, rise_word, fall_word, qr[0], qf[0]);
      end
    end
  end

  task automatic burst(input int n, input real ph, input logic en, input logic [7:0] base);
    @(negedge clk);
    #(ph);
    cap_en = en;
    for (int i = 0; i < n; i++) begin
      dq = 8'(base + 2 * i);
      #0.3 dqs = 1'b1;
      if (en) begin qr.push_back(dq); wr0++; end
      #1.7 dq = 8'(base + 2 * i + 1);
      #0.3 dqs = 1'b0;
      if (en) begin qf.push_back(dq); wr1++; end
      #1.7;
    end
    cap_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic lone(input logic en_r, input logic en_f, input logic [7:0] b);
    @(negedge clk);
    #0.9;
    cap_en = en_r;
    dq = b;
    #0.3 dqs = 1'b1;
    if (en_r) begin qr.push_back(dq); wr0++; end
    #0.5 cap_en = en_f;
    #1.2 dq = ~b;
    #0.3 dqs = 1'b0;
    if (en_f) begin qf.push_back(dq); wr1++; end
    #1.0 cap_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1 rst = 1'b1;
    mv = 1'b0;
    wr0 = 0; wr1 = 0; s1r = 0; s2r = 0; s1f = 0; s2f = 0; rdn = 0;
    qr.delete(); qf.delete();
    repeat (3) @(negedge clk);
    vectors++;
    if (rd_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R7 reset rd_valid=%b expected 0", rd_valid);
    end
    #1 rst = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog expired (R3) got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    tag = "R7";
    do_reset();
    tag = "R1";
    burst(2, 0.2, 1'b1, 8'h10);
    burst(2, 0.9, 1'b1, 8'h20);
    tag = "R2";
    burst(4, 1.4, 1'b1, 8'h40);
    burst(4, 0.2, 1'b1, 8'h80);
    burst(3, 0.9, 1'b1, 8'hA0);
    tag = "R6";
    burst(4, 0.9, 1'b0, 8'hE0);
    tag = "R3";
    lone(1'b1, 1'b0, 8'h5A);
    lone(1'b0, 1'b1, 8'h33);
    burst(2, 1.4, 1'b1, 8'hC0);
    tag = "R4";
    for (int k = 0; k < 6; k++) burst(1 + k % 4, 0.2 + 0.6 * (k % 3), 1'b1, 8'(16 * k + 1));
    tag = "R7";
    lone(1'b1, 1'b0, 8'h77);
    do_reset();
    burst(4, 1.4, 1'b1, 8'hF0);
    burst(2, 0.2, 1'b1, 8'h01);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule